// File: doc/BRIEF.md
# Key-Gated Watchdog Timer with Selectable Prescaler

This block is a hardware watchdog built around an up-counter. Software writes a start value into the count register, picks one of eight clock divisions in the control register and sets the run bit. While running, the counter advances by one each time the prescaler produces a tick. When it steps past its all-ones value it wraps to zero, latches an overflow flag and holds a reset request high until software clears the flag. To get a timeout of N ticks, software loads 2^16 minus N.

Both registers are 32 bits wide and guard themselves with a fixed pattern in their upper bits. A write whose upper bits do not match is dropped silently. An accepted write does not take effect at once. It is held for a fixed synchronisation window, during which a readable busy bit is set. A further accepted write inside the window restarts the window, and all held values then take effect on the same edge.

Top module: `kwdt_top`

## Requirements
- R1: A write to the control register (wr_addr=0) is accepted only when wr_data[31:8] equals 0xA5A5A5. Its payload uses bit 7 as run enable, bit 4 as the overflow-flag write and bits 2:0 as the divider code.
- R2: A write to the count register (wr_addr=1) is accepted only when wr_data[31:16] equals 0x5A5A. Bits 15:0 are the new count.
- R3: A write with a wrong key changes no state, does not set busy and raises no error.
- R4: Every accepted write sets busy (control bit 5) for SYNC_CYC=2 clocks. The written values become visible on the edge at which busy clears.
- R5: Divider codes 0 to 7 give a tick every 1, 4, 16, 32, 64, 128, 1024 and 4096 clocks. The first tick arrives that many clocks after the enable takes effect.
- R6: While enabled, the count rises by one per tick from the loaded value. A load of 65536-N overflows on the Nth tick.
- R7: On a tick at count 0xFFFF the count wraps to 0, the overflow flag (control bit 4) is set and reset_req goes high.
- R8: The overflow flag and reset_req stay high until a control write with bit 4 = 0 takes effect. A control write with bit 4 = 1 leaves them set.
- R9: While the enable is clear, the count holds its value.
- R10: After reset, both registers read zero and reset_req is low.
- R11: With the count loaded with 0xFFFF and divider code 0, reset_req rises one clock after the enable takes effect.

Register read layout: rd_addr=0 returns {24'b0, en, 1'b0, busy, ovf, 1'b0, div[2:0]}; rd_addr=1 returns {16'b0, count}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | 0 selects control, 1 selects count |
| wr_data | input | 32 | Write word: key in the upper bits, payload in the lower bits |
| rd_addr | input | 1 | Read select, same encoding as wr_addr |
| rd_data | output | 32 | Combinational read of the selected register |
| reset_req | output | 1 | High while the overflow flag is set |

## Verification
The bench uses the default build: a 16-bit count, a 2-clock synchronisation window and the full eight-code prescaler with a 12-bit divide counter. Because the window is short, the landing edge of every write can be checked to the exact cycle. A load of 0xFFFF or 0xFFFE makes the slowest divisions, 1024 and 4096, overflow within a few thousand cycles, so these can be timed exactly as well. Back-to-back writes to the count and control registers show that held values take effect together. The fastest division, combined with a load of 0xFFFF, exposes the one-clock reaction from enable to reset request.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int unsigned KWDT_SEL_W = 3;
   localparam int unsigned KWDT_NDIV  = 1 << KWDT_SEL_W;

   // control payload bit positions (software-visible layout)
   localparam int unsigned CTL_RUN_BIT  = 7;
   localparam int unsigned CTL_BUSY_BIT = 5;
   localparam int unsigned CTL_OVF_BIT  = 4;

   typedef enum logic {
      KREG_CTRL = 1'b0,
      KREG_CNT  = 1'b1
   } kwdt_reg_e;

   // clocks per tick for each divider code
   function automatic int unsigned div_of(input int unsigned code);
      case (code)
         0: div_of = 1;
         1: div_of = 4;
         2: div_of = 16;
         3: div_of = 32;
         4: div_of = 64;
         5: div_of = 128;
         6: div_of = 1024;
         default: div_of = 4096;
      endcase
   endfunction
endpackage

// File: rtl/kwdt_regif.sv
module kwdt_regif
   import kwdt_pkg::*;
#(
   parameter int unsigned CNT_W         = 16,
   parameter int unsigned SYNC_CYC      = 2,
   parameter logic [31:0] CTRL_KEY_WORD = 32'hA5A5_A500,
   parameter logic [31:0] CNT_KEY_WORD  = 32'h5A5A_0000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_addr,
   input  logic [31:0]           wr_data,
   output logic                  busy,
   output logic                  run,
   output logic [KWDT_SEL_W-1:0] dsel,
   output logic                  ctl_land,
   output logic                  clr_ovf,
   output logic                  cnt_load,
   output logic [CNT_W-1:0]      cnt_val
);
   localparam int unsigned SW = $clog2(SYNC_CYC + 1);

   logic                  ctrl_hit, cnt_hit, acc, land;
   logic [SW-1:0]         sync_q;
   logic                  pc_v, pc_run, pc_clr;
   logic [KWDT_SEL_W-1:0] pc_dsel;
   logic                  pn_v;
   logic [CNT_W-1:0]      pn_val;

   assign ctrl_hit = wr_en && (wr_addr == KREG_CTRL) &&
                     (wr_data[31:8] == CTRL_KEY_WORD[31:8]);
   assign cnt_hit  = wr_en && (wr_addr == KREG_CNT) &&
                     (wr_data[31:CNT_W] == CNT_KEY_WORD[31:CNT_W]);
   assign acc      = ctrl_hit || cnt_hit;
   // held values land when the window expires without a fresh write
   assign land     = (sync_q == SW'(1)) && !acc;
   assign busy     = (sync_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else if (acc) begin
         sync_q <= SW'(SYNC_CYC);
      end else if (sync_q != '0) begin
         sync_q <= sync_q - SW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_v    <= 1'b0;
         pc_run  <= 1'b0;
         pc_clr  <= 1'b0;
         pc_dsel <= '0;
         run     <= 1'b0;
         dsel    <= '0;
      end else if (ctrl_hit) begin
         pc_v    <= 1'b1;
         pc_run  <= wr_data[CTL_RUN_BIT];
         pc_clr  <= ~wr_data[CTL_OVF_BIT];
         pc_dsel <= wr_data[KWDT_SEL_W-1:0];
      end else if (land && pc_v) begin
         pc_v <= 1'b0;
         run  <= pc_run;
         dsel <= pc_dsel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pn_v   <= 1'b0;
         pn_val <= '0;
      end else if (cnt_hit) begin
         pn_v   <= 1'b1;
         pn_val <= wr_data[CNT_W-1:0];
      end else if (land) begin
         pn_v <= 1'b0;
      end
   end

   assign ctl_land = land && pc_v;
   assign clr_ovf  = land && pc_v && pc_clr;
   assign cnt_load = land && pn_v;
   assign cnt_val  = pn_val;

   AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> busy);                                             // R4
   AST_WRONG_KEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !acc) |=> !busy);                                // R3
   AST_RUN_ONLY_ON_LAND: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_land |=> $stable(run));                               // R4
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
   import kwdt_pkg::*;
#(
   parameter int unsigned PRE_W       = 12,
   parameter bit          PRESCALE_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   input  logic                  restart,
   input  logic [KWDT_SEL_W-1:0] dsel,
   output logic                  tick
);
   generate
      if (PRESCALE_EN) begin : g_div
         logic [PRE_W-1:0]     pre_q;
         logic [KWDT_NDIV-1:0] tc;

         for (genvar k = 0; k < KWDT_NDIV; k++) begin : g_tc
            localparam int unsigned DV = div_of(k);
            if (DV > (1 << PRE_W)) begin : g_bad
               $error("prescaler width too small for divider set");
            end
            assign tc[k] = (pre_q == PRE_W'(DV - 1));
         end

         assign tick = run && tc[dsel];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (restart || !run || tick) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + PRE_W'(1);
            end
         end

         AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !restart && !tick) |=> (pre_q != '0));        // R5
      end else begin : g_nodiv
         assign tick = run;
      end
   endgenerate

   AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);                                           // R9
endmodule

// File: rtl/kwdt_upcnt.sv
module kwdt_upcnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             clr_ovf,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   logic at_top;
   assign at_top = (count == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (tick) begin
         count <= count + CNT_W'(1);
      end
   end

   // a fresh overflow wins over a clear landing on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (tick && !load && at_top) begin
         ovf <= 1'b1;
      end else if (clr_ovf) begin
         ovf <= 1'b0;
      end
   end

   AST_OVF_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> ($past(tick) && ($past(count) == {CNT_W{1'b1}}))); // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);                                // R8
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count));                      // R9
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && at_top) |=> (count == '0));              // R7
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int unsigned CNT_W         = 16,
   parameter int unsigned SYNC_CYC      = 2,
   parameter int unsigned PRE_W         = 12,
   parameter bit          PRESCALE_EN   = 1'b1,
   parameter logic [31:0] CTRL_KEY_WORD = 32'hA5A5_A500,
   parameter logic [31:0] CNT_KEY_WORD  = 32'h5A5A_0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_addr,
   input  logic [31:0] wr_data,
   input  logic        rd_addr,
   output logic [31:0] rd_data,
   output logic        reset_req
);
   if (CNT_W < 2 || CNT_W > 24) begin : g_chk_w
      $error("CNT_W must lie in 2..24");
   end
   if (SYNC_CYC < 1) begin : g_chk_s
      $error("SYNC_CYC must be at least 1");
   end

   logic                  busy, run, ctl_land, clr_ovf, cnt_load, tick, ovf;
   logic [KWDT_SEL_W-1:0] dsel;
   logic [CNT_W-1:0]      cnt_val, count;
   logic [31:0]           ctrl_word;

   kwdt_regif #(
      .CNT_W(CNT_W), .SYNC_CYC(SYNC_CYC),
      .CTRL_KEY_WORD(CTRL_KEY_WORD), .CNT_KEY_WORD(CNT_KEY_WORD)
   ) u_regif (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .run(run), .dsel(dsel),
      .ctl_land(ctl_land), .clr_ovf(clr_ovf), .cnt_load(cnt_load),
      .cnt_val(cnt_val)
   );

   kwdt_prescaler #(.PRE_W(PRE_W), .PRESCALE_EN(PRESCALE_EN)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(ctl_land),
      .dsel(dsel), .tick(tick)
   );

   kwdt_upcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
      .load_val(cnt_val), .clr_ovf(clr_ovf), .count(count), .ovf(ovf)
   );

   always_comb begin
      ctrl_word                    = '0;
      ctrl_word[CTL_RUN_BIT]       = run;
      ctrl_word[CTL_BUSY_BIT]      = busy;
      ctrl_word[CTL_OVF_BIT]       = ovf;
      ctrl_word[KWDT_SEL_W-1:0]    = dsel;
   end

   assign rd_data   = (rd_addr == KREG_CNT) ? {{(32-CNT_W){1'b0}}, count} : ctrl_word;
   assign reset_req = ovf;

   AST_REQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reset_req) |-> $past(run));                          // R7
endmodule

// File: tb/tb_kwdt_top.sv
`timescale 1ns/1ps
module tb_kwdt_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_addr = 1'b0;
   logic [31:0] rd_data;
   logic        reset_req;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   kwdt_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .reset_req(reset_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic a, output logic [31:0] d);
      rd_addr = a;
      #0.5;
      d = rd_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic test_reset();
      logic [31:0] v;
      rd(1'b0, v); check("R10 ctrl after reset", v, 32'h0);
      rd(1'b1, v); check("R10 count after reset", v, 32'h0);
      check("R10 reset_req after reset", {31'b0, reset_req}, 32'h0);
   endtask

   task automatic test_wrong_key();
      logic [31:0] v;
      wr(1'b0, 32'hA5A5_A485);
      rd(1'b0, v); check("R3 bad ctrl key no busy", v, 32'h0);
      wr(1'b1, 32'h5A5B_00FF);
      rd(1'b0, v); check("R3 bad count key no busy", v, 32'h0);
      wr(1'b0, 32'h5A5A_0080);   // count key on control address: R1
      wr(1'b1, 32'hA5A5_A5FF);   // control key on count address: R2
      idle(3);
      rd(1'b0, v); check("R1 ctrl untouched by wrong key", v, 32'h0);
      rd(1'b1, v); check("R2 count untouched by wrong key", v, 32'h0);
   endtask

   task automatic test_busy_land();
      logic [31:0] v;
      wr(1'b1, 32'h5A5A_1234);
      rd(1'b0, v); check("R4 busy first cycle", v, 32'h20);
      rd(1'b1, v); check("R4 count not landed yet", v, 32'h0);
      idle(1);
      rd(1'b0, v); check("R4 busy second cycle", v, 32'h20);
      idle(1);
      rd(1'b0, v); check("R4 busy cleared", v, 32'h0);
      rd(1'b1, v); check("R2 count landed", v, 32'h1234);
   endtask

   task automatic test_div4_steps();
      logic [31:0] v;
      wr(1'b1, 32'h5A5A_0100);
      wr(1'b0, 32'hA5A5_A581);   // run, code 1 (divide by 4)
      idle(2);
      rd(1'b0, v); check("R1 ctrl landed run+code1", v, 32'h81);
      rd(1'b1, v); check("R4 count landed with ctrl", v, 32'h100);
      idle(7);
      rd(1'b1, v); check("R5 div4 one tick", v, 32'h101);
      idle(1);
      rd(1'b1, v); check("R6 div4 two ticks", v, 32'h102);
      wr(1'b0, 32'hA5A5_A501);   // stop
      idle(2);
   endtask

   task automatic test_hold();
      logic [31:0] a, b;
      rd(1'b1, a);
      idle(40);
      rd(1'b1, b);
      check("R9 count held while stopped", b, a);
      check("R9 no request while stopped", {31'b0, reset_req}, 32'h0);
   endtask

   task automatic test_timeout(input string req, input logic [15:0] load,
                               input logic [2:0] code, input int n_ticks, input int dv);
      logic [31:0] v;
      wr(1'b1, {16'h5A5A, load});
      wr(1'b0, {24'hA5A5A5, 5'b10000, code});
      idle(1 + n_ticks * dv);
      check({req, " no request one cycle early"}, {31'b0, reset_req}, 32'h0);
      idle(1);
      check({req, " request at timeout"}, {31'b0, reset_req}, 32'h1);
      rd(1'b1, v); check({req, " R7 count wrapped"}, v, 32'h0);
      rd(1'b0, v); check({req, " R7 flag set"}, v & 32'h10, 32'h10);
   endtask

   task automatic test_clear();
      logic [31:0] v;
      wr(1'b0, 32'hA5A5_A516);   // stop, flag write 1: keep
      idle(2);
      check("R8 flag kept by writing 1", {31'b0, reset_req}, 32'h1);
      wr(1'b0, 32'hA5A5_A506);   // stop, flag write 0: clear
      idle(1);
      check("R8 flag held during busy", {31'b0, reset_req}, 32'h1);
      idle(1);
      check("R8 flag cleared", {31'b0, reset_req}, 32'h0);
      rd(1'b0, v); check("R8 ctrl after clear", v, 32'h06);
   endtask

   task automatic test_fast_fire();
      wr(1'b1, 32'h5A5A_FFFF);
      wr(1'b0, 32'hA5A5_A580);
      idle(2);
      check("R11 not yet at enable landing", {31'b0, reset_req}, 32'h0);
      idle(1);
      check("R11 fires one clock after enable", {31'b0, reset_req}, 32'h1);
      wr(1'b0, 32'hA5A5_A500);
      idle(2);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      test_reset();
      test_wrong_key();
      test_busy_land();
      test_div4_steps();
      test_hold();
      test_timeout("R6 div1024 N=1", 16'hFFFF, 3'd6, 1, 1024);
      test_clear();
      test_timeout("R5 div4096 N=2", 16'hFFFE, 3'd7, 2, 4096);
      test_clear();
      test_timeout("R6 div16 N=3", 16'hFFFD, 3'd2, 3, 16);
      test_clear();
      test_fast_fire();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule